// File: doc/BRIEF.md
# RAM-Backed Multi-Tap Delay Line

The block delays a stream of W-bit words and presents the stream at N evenly spaced taps. Tap k carries the word that entered K·M accepted shifts earlier. Conceptually there are N segments in series, each M words deep. The output of one segment is a tap and also feeds the following segment. A shift happens only on a clock edge where the shift enable is high. Cycles with the enable low leave every output untouched. This suits filter delay lines and correlators that need many long, equal-length delays.

The delays are not built from a long chain of flip-flops. One synchronous RAM of depth M holds all N segment lanes side by side in a word of width W·N. A single pointer walks through the RAM modulo M. On each shift the block writes back the word it read, shifted up by one lane, with the new input in lane 0. It then reads the next location ahead of time. The registered read port is also the tap output register. The RAM size limits are checked when the design is elaborated. A valid flag shows when every tap holds real data.

Top module: `ram_tap_delay`

## Requirements
- R1: After a shift, tap k (1 ≤ k < N) on bits [k·W-1:(k-1)·W] of `taps` equals the input word accepted k·M shifts before the most recent accepted shift plus one, that is the word accepted at shift index s−k·M+1 when the latest shift has index s.
- R2: The last tap, on the top W bits of `taps`, is the oldest word in an N·M-deep history of accepted words.
- R3: The `taps` bus is W·N bits wide. Elaboration fails if W·M·N exceeds 9216, if W·N exceeds 36, or if M is below 2.
- R4: With the shift enable held high, the block accepts one word per cycle. Taps reflect a shift on the clock edge that performs it, including across every wrap of the modulo-M pointer.
- R5: While the shift enable is low, `taps`, `taps_valid` and the internal pointer hold, whatever the value on `din`.
- R6: `taps_valid` is low from reset until N·M shifts have been accepted, goes high on the edge that accepts the N·M-th shift, and then stays high until reset.
- R7: While reset is asserted, and right after it, `taps` reads all zeros and `taps_valid` is low. The shift history restarts from empty.
- R8: When the enable is asserted irregularly, the taps depend only on the sequence of accepted words and not on the cycles between shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Accept `din` and advance every segment by one word |
| din | input | W | Word entering the first segment |
| taps | output | W·N | Tap k on bits [k·W-1:(k-1)·W] |
| taps_valid | output | 1 | High once N·M shifts have been accepted since reset |

## Verification
The bench uses a non-power-of-two segment length, so the pointer wrap is exercised at an awkward boundary. A design that wraps at the wrong count would produce taps that drift from the reference history after the first wrap. Irregular enable patterns and long stalls with a changing input expose two faults. A design that shifts on idle cycles shows taps that skip ahead. A design that lets the RAM read run freely shows taps that change while stalled. The valid edge is checked on the exact shift where it should rise, so an off-by-one fill count is caught. A reset in the middle of the run checks that the history and the flag restart cleanly while the RAM still holds stale words.

// File: rtl/srt_pkg.sv
package srt_pkg;
  // Capacity of one embedded memory block, used for elaboration checks.
  localparam int unsigned RAM_MAX_BITS = 9216;
  localparam int unsigned RAM_MAX_WORD = 36;
  localparam int unsigned SEG_MIN_LEN  = 2;
endpackage

// File: rtl/srt_ptr.sv
// Modulo-LEN rotating address with a look-ahead output.
module srt_ptr #(
  parameter int unsigned LEN = 16,
  localparam int unsigned PW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] ptr_nxt
);
  localparam logic [PW-1:0] LAST = PW'(LEN - 1);

  logic [PW-1:0] ptr_d;

  always_comb begin
    ptr_nxt = (ptr == LAST) ? '0 : ptr + PW'(1);
    ptr_d   = adv ? ptr_nxt : ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end
endmodule

// File: rtl/srt_ram.sv
// Simple dual-port synchronous RAM with a registered read that returns old data.
module srt_ram #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/srt_fill.sv
// Saturating count of accepted shifts; flags when TARGET is reached.
module srt_fill #(
  parameter int unsigned TARGET = 64,
  localparam int unsigned CW    = $clog2(TARGET + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic full
);
  localparam logic [CW-1:0] TOP = CW'(TARGET);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    full  = (cnt_q == TOP);
    cnt_d = (adv && !full) ? cnt_q + CW'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ram_tap_delay.sv
module ram_tap_delay #(
  parameter int unsigned W = 8,
  parameter int unsigned M = 16,
  parameter int unsigned N = 4,
  localparam int unsigned WORD_W = W * N,
  localparam int unsigned PW     = (M > 1) ? $clog2(M) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [W-1:0]      din,
  output logic [W*N-1:0]    taps,
  output logic              taps_valid
);
  import srt_pkg::*;

  // Elaboration-time budget checks.
  generate
    if (W * M * N > RAM_MAX_BITS) begin : g_err_bits
      $error("ram_tap_delay: W*M*N exceeds the memory bit budget");
    end
    if (WORD_W > RAM_MAX_WORD) begin : g_err_width
      $error("ram_tap_delay: W*N exceeds the widest memory word");
    end
    if (M < SEG_MIN_LEN) begin : g_err_len
      $error("ram_tap_delay: segment length must be at least 2");
    end
  endgenerate

  logic [PW-1:0]     ptr_q;
  logic [PW-1:0]     ptr_ahead;
  logic [WORD_W-1:0] head_word;
  logic [WORD_W-1:0] wb_word;

  srt_ptr #(.LEN(M)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (shift_en),
    .ptr     (ptr_q),
    .ptr_nxt (ptr_ahead)
  );

  // Write-back word: every lane moves up one segment, new input enters lane 0.
  generate
    if (N > 1) begin : g_multi
      always_comb wb_word = {head_word[WORD_W-W-1:0], din};
    end else begin : g_single
      always_comb wb_word = din;
    end
  endgenerate

  srt_ram #(.WORD_W(WORD_W), .DEPTH(M)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (shift_en),
    .wr_addr (ptr_q),
    .wr_data (wb_word),
    .rd_en   (shift_en),
    .rd_addr (ptr_ahead),
    .rd_data (head_word)
  );

  srt_fill #(.TARGET(N * M)) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (shift_en),
    .full  (taps_valid)
  );

  assign taps = head_word;
endmodule

// File: rtl/srt_chk.sv
module srt_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned M  = 16,
  parameter int unsigned N  = 4,
  parameter int unsigned PW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           shift_en,
  input logic [W*N-1:0] taps,
  input logic           taps_valid,
  input logic [PW-1:0]  ptr
);
  a_r5_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(taps));

  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(ptr));

  a_r5_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(taps_valid));

  a_r6_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    taps_valid |=> taps_valid);

  a_r6_valid_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(taps_valid) |-> $past(shift_en));

  a_r4_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < int'(M));

  a_r4_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !$stable(ptr));
endmodule

bind ram_tap_delay srt_chk #(.W(W), .M(M), .N(N), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_en   (shift_en),
  .taps       (taps),
  .taps_valid (taps_valid),
  .ptr        (ptr_q)
);

// File: tb/ram_tap_delay_tb.sv
`timescale 1ns/1ps
module ram_tap_delay_tb;
  localparam int unsigned W = 8;
  localparam int unsigned M = 5;
  localparam int unsigned N = 3;
  localparam int DEPTH = N * M;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           shift_en;
  logic [W-1:0]   din;
  logic [W*N-1:0] taps;
  logic           taps_valid;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] hist[$];

  always #4 clk = ~clk;

  ram_tap_delay #(.W(W), .M(M), .N(N)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .din        (din),
    .taps       (taps),
    .taps_valid (taps_valid)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Compare all outputs against the behavioural history.
  task automatic check_outputs(string phase);
    logic exp_valid;
    exp_valid = (hist.size() >= DEPTH);
    n_cmp++;
    if (taps_valid !== exp_valid) begin
      n_bad++;
      $display("FAIL R6 [%s] taps_valid actual=%0b expected=%0b", phase, taps_valid, exp_valid);
    end
    if (exp_valid) begin
      for (int k = 1; k <= int'(N); k++) begin
        logic [W-1:0] got, exp;
        got = taps[k*W-1 -: W];
        exp = hist[k*M-1];
        n_cmp++;
        if (got !== exp) begin
          n_bad++;
          $display("FAIL %s [%s] tap%0d actual=%h expected=%h",
                   (k == int'(N)) ? "R2" : "R1", phase, k, got, exp);
        end
      end
    end
  endtask

  task automatic check_reset_state();
    n_cmp++;
    if (taps !== '0 || taps_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 reset state actual=%h/%0b expected=0/0", taps, taps_valid);
    end
  endtask

  task automatic step(bit en, logic [W-1:0] d, string phase);
    @(negedge clk);
    check_outputs(phase);
    shift_en = en;
    din      = d;
    if (en) begin
      hist.push_front(d);
      if (hist.size() > DEPTH) void'(hist.pop_back());
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; shift_en = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    check_reset_state();                      // R7
    n_cmp++;                                  // R3: tap bus width
    if ($bits(taps) != W * N) begin
      n_bad++;
      $display("FAIL R3 tap width actual=%0d expected=%0d", $bits(taps), W * N);
    end
    rst_n = 1'b1;

    // R4: continuous shifting across many pointer wraps.
    for (int i = 0; i < 60; i++) step(1'b1, W'(i * 7 + 3), "R4");
    // R8: irregular enable pattern.
    for (int i = 0; i < 150; i++) step(($urandom % 3) != 0, W'($urandom), "R8");
    // R5: long stall with a changing input.
    for (int i = 0; i < 25; i++) step(1'b0, W'($urandom), "R5");
    for (int i = 0; i < 100; i++) step(($urandom % 4) == 0, W'($urandom), "R8");

    // R7: reset in the middle of the run, history restarts.
    @(negedge clk);
    rst_n = 1'b0; shift_en = 1'b0;
    hist.delete();
    @(negedge clk);
    check_reset_state();                      // R7
    rst_n = 1'b1;
    // R6: refill, valid must rise exactly on the N*M-th shift.
    for (int i = 0; i < 40; i++) step(1'b1, W'(8'hA0 + i), "R6");
    for (int i = 0; i < 30; i++) step(i[0], W'($urandom), "R8");
    step(1'b0, '0, "R5");
    @(negedge clk);
    check_outputs("R5");

    summary();
    $finish;
  end
endmodule